// File: doc/BRIEF.md
# Sticky Button Capture Port

This block is a one-byte input port that connects eight mechanical buttons to a small 8-bit processor bus. Each button pin goes through a synchroniser and then a per-button debounce counter. The debounced press then sets a sticky bit in a capture register. A tap that starts and ends between two software polls is therefore still seen at the next poll.

Software reads the byte at the port's address. The block does no address decoding: a decoder elsewhere supplies the select line, and the processor supplies the read strobe. While both are high, the capture register is driven onto the shared data bus. At all other times the bus is left floating.

One clock after the read strobe ends, the captured bits are cleared. Bits for buttons that are still held down are set again at once. Software can therefore tell "still held" from "tapped since the last poll". The read strobe must span at least one rising clock edge to count as a read.

Top module: `btn_latch_port`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) clears the capture register and the debounce state. The next read returns 0x00, even if the pins are held pressed during reset.
- R2: data_io is high-impedance unless sel_i and rd_i are both high. If only one of them is high, the bus is also left floating.
- R3: A read returns one bit per button, with 1 meaning pressed. The bits are: bit 7 up, bit 6 down, bit 5 left, bit 4 right, bit 3 red, bit 2 blue, bit 1 yellow, bit 0 green. Pins are active-low, and pin index n maps to data bit n.
- R4: A pin level counts only after it has been stable for DEBOUNCE_CYCLES (default 16) synchronised clocks. A press that is first seen at a rising edge appears in the capture register at the 19th rising edge from that one, counting it as the first. A press lasting 15 clocks is ignored.
- R5: A captured bit stays set after the button is released, for as long as no read has completed.
- R6: On the first rising edge after a read strobe (sel_i and rd_i) ends, every captured bit whose button is released is cleared.
- R7: A bit whose button is still held when a read completes stays set after the clear.
- R8: Raising only sel_i or only rd_i, or a strobe that does not span a rising edge, does not clear any captured bit.
- R9: A press whose debounced level becomes valid in the same clock as a clear wins over the clear. The bit is visible right after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_pin_i | input | 8 | Raw button pins, active low, asynchronous |
| sel_i | input | 1 | Port select from the external address decoder |
| rd_i | input | 1 | Read strobe from the processor |
| data_io | inout | 8 | Shared data bus; driven only during a selected read |

## Verification
The bench measures the exact latency from a pin falling to its captured bit. A debounce counter that is off by one, or an extra synchroniser stage, therefore shifts the bit by a cycle and is reported. A 15-clock glitch is applied to catch a filter that accepts presses that are too short.

For the clear, the bench covers three cases:
- a half-asserted strobe, which a design gating only on select would wrongly treat as a read;
- a held button across a read, which a design that clears everything would lose for a cycle;
- a press whose debounced level lands exactly on the clearing edge, which a design giving the clear priority would show as zero for one poll.

Bit ordering is checked with asymmetric patterns, so a reversed or shifted byte cannot match.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;

   // Data-bus bit position of each button
   localparam int BTN_UP     = 7;
   localparam int BTN_DOWN   = 6;
   localparam int BTN_LEFT   = 5;
   localparam int BTN_RIGHT  = 4;
   localparam int BTN_RED    = 3;
   localparam int BTN_BLUE   = 2;
   localparam int BTN_YELLOW = 1;
   localparam int BTN_GREEN  = 0;

   localparam int PORT_BTNS  = 8;
   localparam int PORT_BUS_W = 8;

   // Counter width able to hold values 0 .. limit-1
   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int   N       = 8,
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] sync_o
);

   logic [STAGES-1:0][N-1:0] stg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int s = 0; s < STAGES; s++) begin
            stg_q[s] <= {N{RST_LVL}};
         end
      end else begin
         stg_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
   parameter int N     = 8,
   parameter int LIMIT = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [N-1:0] lvl_i,   // 1 = pressed
   output logic [N-1:0] lvl_o
);

   import btn_port_pkg::*;

   localparam int CW = cnt_width(LIMIT + 1);

   generate
      if (LIMIT == 0) begin : g_bypass
         // No filtering: one register stage only
         always_ff @(posedge clk_i) begin
            if (rst_i) lvl_o <= '0;
            else       lvl_o <= lvl_i;
         end
      end else begin : g_filter
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         for (genvar i = 0; i < N; i++) begin : g_bit
            logic [CW-1:0] cnt_q;
            logic          st_q;

            always_ff @(posedge clk_i) begin
               if (rst_i) begin
                  cnt_q <= '0;
                  st_q  <= 1'b0;
               end else if (lvl_i[i] == st_q) begin
                  cnt_q <= '0;
               end else if (cnt_q == LAST) begin
                  st_q  <= lvl_i[i];
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end

            assign lvl_o[i] = st_q;
         end
      end
   endgenerate

endmodule

// File: rtl/btn_capture.sv
module btn_capture #(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [N-1:0] held_i,     // debounced, 1 = pressed
   input  logic         rd_act_i,   // select and strobe both high
   output logic [N-1:0] cap_o
);

   logic         rd_q;
   logic         clr;
   logic [N-1:0] cap_q;
   logic [N-1:0] cap_d;

   assign clr = rd_q & ~rd_act_i;

   // A held or newly debounced press wins over the clear
   always_comb begin
      cap_d = (clr ? '0 : cap_q) | held_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rd_q  <= 1'b0;
         cap_q <= '0;
      end else begin
         rd_q  <= rd_act_i;
         cap_q <= cap_d;
      end
   end

   assign cap_o = cap_q;

endmodule

// File: rtl/btn_latch_port.sv
module btn_latch_port #(
   parameter int   NUM_BTN         = btn_port_pkg::PORT_BTNS,
   parameter int   DATA_W          = btn_port_pkg::PORT_BUS_W,
   parameter int   SYNC_STAGES     = 2,
   parameter int   DEBOUNCE_CYCLES = 16,
   parameter logic ACTIVE_LOW      = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_BTN-1:0] btn_pin_i,
   input  logic               sel_i,
   input  logic               rd_i,
   inout  wire  [DATA_W-1:0]  data_io
);

   localparam int PAD_W = (DATA_W > NUM_BTN) ? DATA_W - NUM_BTN : 1;

   // Elaboration-time parameter checks
   if (NUM_BTN < 1 || NUM_BTN > DATA_W) begin : g_chk_width
      $error("btn_latch_port: NUM_BTN must be 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("btn_latch_port: SYNC_STAGES must be at least 2");
   end
   if (DEBOUNCE_CYCLES < 0) begin : g_chk_db
      $error("btn_latch_port: DEBOUNCE_CYCLES must not be negative");
   end

   logic [NUM_BTN-1:0] sync_pin;
   logic [NUM_BTN-1:0] press_lvl;
   logic [NUM_BTN-1:0] deb_lvl;
   logic [NUM_BTN-1:0] cap_q;
   logic [DATA_W-1:0]  rd_word;
   logic               rd_act;

   btn_sync #(
      .N       (NUM_BTN),
      .STAGES  (SYNC_STAGES),
      .RST_LVL (ACTIVE_LOW)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .raw_i  (btn_pin_i),
      .sync_o (sync_pin)
   );

   generate
      if (ACTIVE_LOW) begin : g_pol_low
         assign press_lvl = ~sync_pin;
      end else begin : g_pol_high
         assign press_lvl = sync_pin;
      end
   endgenerate

   btn_debounce #(
      .N     (NUM_BTN),
      .LIMIT (DEBOUNCE_CYCLES)
   ) u_deb (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .lvl_i (press_lvl),
      .lvl_o (deb_lvl)
   );

   assign rd_act = sel_i & rd_i;

   btn_capture #(
      .N (NUM_BTN)
   ) u_cap (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .held_i   (deb_lvl),
      .rd_act_i (rd_act),
      .cap_o    (cap_q)
   );

   generate
      if (DATA_W == NUM_BTN) begin : g_word_full
         assign rd_word = cap_q;
      end else begin : g_word_pad
         assign rd_word = {{PAD_W{1'b0}}, cap_q};
      end
   endgenerate

   assign data_io = rd_act ? rd_word : {DATA_W{1'bz}};

endmodule

// File: rtl/btn_latch_port_chk.sv
module btn_latch_port_chk #(
   parameter int N = 8
) (
   input logic         clk_i,
   input logic         rst_i,
   input logic         sel_i,
   input logic         rd_i,
   input logic [N-1:0] deb_lvl,
   input logic [N-1:0] cap_q
);

   logic rd_prev;
   logic rd_now;
   logic rd_end;

   assign rd_now = sel_i & rd_i;
   assign rd_end = rd_prev & ~rd_now;

   always_ff @(posedge clk_i) begin
      if (rst_i) rd_prev <= 1'b0;
      else       rd_prev <= rd_now;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (cap_q == '0));

   // R5
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd_end |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

   // R6
   clear_released_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_end && (deb_lvl == '0)) |=> (cap_q == '0));

   // R7 and R9: a debounced press is in the capture register one edge later, clear or not
   held_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (deb_lvl != '0) |=> ((cap_q & $past(deb_lvl)) == $past(deb_lvl)));

   // R8
   half_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rd_now && !rd_prev) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

endmodule

bind btn_latch_port btn_latch_port_chk #(.N(NUM_BTN)) chk_i (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .sel_i   (sel_i),
   .rd_i    (rd_i),
   .deb_lvl (deb_lvl),
   .cap_q   (cap_q)
);

// File: tb/btn_latch_port_tb_top.sv
module btn_latch_port_tb_top;

   localparam int DB = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] btn_n = 8'hFF;
   logic       sel = 1'b0;
   logic       rd = 1'b0;
   wire  [7:0] data_w;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   btn_latch_port #(
      .NUM_BTN         (8),
      .DATA_W          (8),
      .SYNC_STAGES     (2),
      .DEBOUNCE_CYCLES (DB),
      .ACTIVE_LOW      (1'b1)
   ) dut_i (
      .clk_i     (clk),
      .rst_i     (rst),
      .btn_pin_i (btn_n),
      .sel_i     (sel),
      .rd_i      (rd),
      .data_io   (data_w)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Strobe shorter than a clock: observes without clearing
   task automatic peek(output logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; rd = 1'b1;
      #1 v = data_w;
      #1 sel = 1'b0; rd = 1'b0;
   endtask

   // Strobe spanning one rising edge: a real read
   task automatic full_read(output logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; rd = 1'b1;
      #1 v = data_w;
      @(negedge clk);
      sel = 1'b0; rd = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic set_pins(input logic [7:0] pressed);
      @(negedge clk);
      btn_n = ~pressed;
   endtask

   task automatic drain();
      logic [7:0] v;
      set_pins(8'h00);
      edges(DB + 6);
      full_read(v);
      edges(2);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      btn_n = 8'h00;
      rst = 1'b1;
      edges(4);
      peek(v);
      chk("R1 pressed pins during reset", v, 8'h00);
      @(negedge clk);
      btn_n = 8'hFF;
      edges(4);
      @(negedge clk);
      rst = 1'b0;
      edges(2);
      peek(v);
      chk("R1 after reset", v, 8'h00);
      @(negedge clk);
      #1 chk("R2 idle bus", data_w, 8'hzz);
   endtask

   task automatic t_latency();
      logic [7:0] v;
      set_pins(8'h08);                // red, bit 3
      edges(DB + 2);
      peek(v);
      chk("R4 not yet captured", v, 8'h00);
      peek(v);
      chk("R4 captured on time", v, 8'h08);
      set_pins(8'h00);
      edges(40);
      peek(v);
      chk("R5 sticky after release", v, 8'h08);
      full_read(v);
      chk("R3 read red", v, 8'h08);
      edges(1);
      peek(v);
      chk("R6 cleared after read", v, 8'h00);
   endtask

   task automatic t_glitch();
      logic [7:0] v;
      set_pins(8'h04);                // blue
      edges(DB - 1);
      set_pins(8'h00);
      edges(40);
      peek(v);
      chk("R4 short glitch ignored", v, 8'h00);
   endtask

   task automatic t_order();
      logic [7:0] v;
      set_pins(8'h81);                // up + green
      edges(DB + 6);
      full_read(v);
      chk("R3 up and green", v, 8'h81);
      edges(3);
      peek(v);
      chk("R7 held bits survive clear", v, 8'h81);
      drain();
      set_pins(8'h32);                // left, right, yellow
      edges(DB + 6);
      set_pins(8'h00);
      edges(DB + 6);
      full_read(v);
      chk("R3 left right yellow", v, 8'h32);
      edges(2);
      peek(v);
      chk("R6 pattern cleared", v, 8'h00);
   endtask

   task automatic t_half_strobe();
      logic [7:0] v;
      set_pins(8'h40);                // down
      edges(DB + 6);
      set_pins(8'h00);
      edges(DB + 6);
      @(negedge clk);
      sel = 1'b1;
      #1 chk("R2 select only floats", data_w, 8'hzz);
      edges(3);
      @(negedge clk);
      sel = 1'b0; rd = 1'b1;
      #1 chk("R2 strobe only floats", data_w, 8'hzz);
      edges(3);
      @(negedge clk);
      rd = 1'b0;
      edges(2);
      peek(v);
      chk("R8 half strobe keeps bit", v, 8'h40);
      drain();
   endtask

   task automatic t_priority();
      logic [7:0] v;
      @(negedge clk);
      btn_n = 8'hF7;                  // red pressed
      edges(DB);
      @(negedge clk);
      sel = 1'b1; rd = 1'b1;
      edges(2);
      @(negedge clk);
      sel = 1'b0; rd = 1'b0;
      edges(1);                       // clearing edge, debounce valid here too
      peek(v);
      chk("R9 press wins over clear", v, 8'h08);
      drain();
   endtask

   initial begin
      edges(200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_glitch();
      t_order();
      t_half_strobe();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule